// File: doc/BRIEF.md
# ALU Status Flag Generator

This block is the arithmetic and logic stage of a 16-bit datapath. It takes two operands, an operation code and an incoming carry, and returns a result together with six status flags. The flags are carry, zero, sign, parity, overflow and auxiliary carry.

Eight operations are supported: add, add with carry, subtract, subtract with borrow, AND, OR, XOR and pass-through. A byte-mode input limits the operation to the low eight bits of each operand. In byte mode the width-dependent flags are taken at bit 7.

The result and the flags are produced combinationally. A registered copy of the flags is also kept. It loads only in a cycle where the flag-write enable is high, so a later instruction can read flags left by an earlier one.

Top module: `alu_flag_gen`

## Requirements
- R1: `op` selects the operation. 0 is add (a+b), 1 is add with carry (a+b+carry_in), 2 is subtract (a-b) and 3 is subtract with borrow (a-b-carry_in). 4 is AND, 5 is OR, 6 is XOR and 7 is pass-through. The result is taken modulo the active width.
- R2: For add and add-with-carry, carry (`flags[0]`) is the carry out of the top bit of the active width. For subtract and subtract-with-borrow, it is set when the unsigned subtraction borrows.
- R3: Overflow (`flags[4]`) is set when the true signed result of an arithmetic operation lies outside the signed range of the active width.
- R4: Auxiliary carry (`flags[5]`) is set by an addition that carries out of bit 3, or by a subtraction that borrows into bit 3.
- R5: Zero (`flags[1]`) is set exactly when the active-width result is all zeros.
- R6: Sign (`flags[2]`) equals the top bit of the active-width result: bit 15 in word mode and bit 7 in byte mode.
- R7: Parity (`flags[3]`) is set when `result[7:0]` holds an even number of one bits. This holds in both widths.
- R8: With `byte_mode` high, only `a[7:0]`, `b[7:0]` and `carry_in` affect the outputs, and `result[15:8]` is zero.
- R9: The logic operations (op 4 to 7) clear carry, overflow and auxiliary carry.
- R10: Pass-through (op 7) returns `b` in the active width.
- R11: `flags_q` resets to zero. It takes the value of `flags` at a rising clock edge where `flag_we` is high, and keeps its value at any edge where `flag_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered flags |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 3 | Operation code |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| a | input | 16 | First operand (minuend) |
| b | input | 16 | Second operand (subtrahend) |
| carry_in | input | 1 | Incoming carry or borrow |
| flag_we | input | 1 | Load enable for `flags_q` |
| result | output | 16 | Operation result |
| flags | output | 6 | Combinational flags {aux, ovf, parity, sign, zero, carry} |
| flags_q | output | 6 | Registered flags |

## Verification
The assertions check several properties on every cycle. They confirm that the logic operations clear the arithmetic flags and that sign and parity track the result bits. They confirm that zero is set only for an empty active-width result, that the high byte is zero in byte mode and that pass-through returns b. They also confirm that the registered flags hold or load according to the write enable. The numeric correctness of carry, borrow, signed overflow and the nibble carry cannot be checked that way. Only the bench's reference model can show it, using directed corner operands at both widths and a pseudo-random sweep over all eight operations.

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         carry_in,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic [5:0]   flags,
  output logic [5:0]   flags_q
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
                         OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6;

  logic         is_arith, is_sub, use_c, cin;
  logic [W-1:0] bx, mask, raw;
  logic [W:0]   sum;
  logic         c4, cbyte, cout, top_r, top_a, top_b, aux_c, ovf;

  assign is_arith = ~op[2];
  assign is_sub   = (op == OP_SUB) | (op == OP_SBB);
  assign use_c    = ((op == OP_ADC) | (op == OP_SBB)) & carry_in;
  assign bx       = is_sub ? ~b : b;
  assign cin      = is_sub ? ~use_c : use_c;
  assign sum      = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};

  assign c4    = a[4] ^ bx[4] ^ sum[4];
  assign cbyte = a[BW] ^ bx[BW] ^ sum[BW];
  assign cout  = byte_mode ? cbyte : sum[W];
  assign mask  = byte_mode ? {{(W-BW){1'b0}}, {BW{1'b1}}} : {W{1'b1}};

  always_comb begin
    case (op)
      OP_AND:  raw = a & b;
      OP_OR:   raw = a | b;
      OP_XOR:  raw = a ^ b;
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: raw = sum[W-1:0];
      default: raw = b;
    endcase
  end

  assign result = raw & mask;
  assign top_r  = byte_mode ? result[BW-1] : result[W-1];
  assign top_a  = byte_mode ? a[BW-1] : a[W-1];
  assign top_b  = byte_mode ? bx[BW-1] : bx[W-1];
  assign ovf    = (top_a == top_b) & (top_r != top_a);
  assign aux_c  = is_sub ? ~c4 : c4;

  assign flags[0] = is_arith & (is_sub ? ~cout : cout);
  assign flags[1] = (result == '0);
  assign flags[2] = top_r;
  assign flags[3] = ~^result[7:0];
  assign flags[4] = is_arith & ovf;
  assign flags[5] = is_arith & aux_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (flag_we) flags_q <= flags;
  end
endmodule

module alu_flag_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op,
  input logic        byte_mode,
  input logic [15:0] b,
  input logic        flag_we,
  input logic [15:0] result,
  input logic [5:0]  flags,
  input logic [5:0]  flags_q
);
  p_logic_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op[2] |-> (flags[0] == 1'b0 && flags[4] == 1'b0 && flags[5] == 1'b0));
  p_sign_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flags[2] == (byte_mode ? result[7] : result[15]));
  p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3] == ($countones(result[7:0]) % 2 == 0));
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] |-> result == 16'h0);
  p_byte_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> result[15:8] == 8'h00);
  p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd7) |-> result == (byte_mode ? {8'h00, b[7:0]} : b));
  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags_q == $past(flags));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_q));
endmodule

bind alu_flag_gen alu_flag_gen_chk u_chk (.*);

// File: tb/alu_flag_gen_bench.sv
`timescale 1ns/1ps
module alu_flag_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic byte_mode = 1'b0, carry_in = 1'b0, flag_we = 1'b0;
  logic [15:0] a = 16'h0, b = 16'h0;
  logic [15:0] result;
  logic [5:0] flags, flags_q;
  int checks = 0, errors = 0;
  logic [5:0] exp_q = 6'h0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  alu_flag_gen u_alu_flag_gen (.clk(clk), .rst_n(rst_n), .op(op), .byte_mode(byte_mode),
    .a(a), .b(b), .carry_in(carry_in), .flag_we(flag_we), .result(result),
    .flags(flags), .flags_q(flags_q));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d bm=%0d a=%h b=%h ci=%0d: actual=%h expected=%h",
               tag, op, byte_mode, a, b, carry_in, act, exp);
    end
  endtask

  task automatic apply(input int o, input int bm, input int va, input int vb,
                       input int ci, input int we);
    int w, mask, half, ua, ub, sa, sb, c, s, res, cy, ov, ax, sv, ones;
    logic [5:0] ef;
    @(negedge clk);
    op = 3'(o); byte_mode = bm[0]; a = 16'(va); b = 16'(vb);
    carry_in = ci[0]; flag_we = we[0];
    w = bm ? 8 : 16; mask = (1 << w) - 1; half = 1 << (w - 1);
    ua = va & mask; ub = vb & mask;
    sa = (ua >= half) ? ua - 2*half : ua;
    sb = (ub >= half) ? ub - 2*half : ub;
    c = (o == 1 || o == 3) ? ci : 0;
    cy = 0; ov = 0; ax = 0;
    case (o)
      0, 1: begin
        s = ua + ub + c; cy = (s > mask) ? 1 : 0; res = s & mask;
        ax = ((ua & 15) + (ub & 15) + c > 15) ? 1 : 0;
        sv = sa + sb + c; ov = (sv >= half || sv < -half) ? 1 : 0;
      end
      2, 3: begin
        s = ua - ub - c; cy = (s < 0) ? 1 : 0; res = s & mask;
        ax = ((ua & 15) - (ub & 15) - c < 0) ? 1 : 0;
        sv = sa - sb - c; ov = (sv >= half || sv < -half) ? 1 : 0;
      end
      4: res = ua & ub;
      5: res = ua | ub;
      6: res = ua ^ ub;
      default: res = ub;
    endcase
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
    ef = {ax[0], ov[0], (ones % 2 == 0), res[w-1], (res == 0), cy[0]};
    #2;
    chk(bm ? "R8/R1 result" : (o == 7 ? "R10 result" : "R1 result"), int'(result), res);
    chk("R2 carry", int'(flags[0]), ef[0]);
    chk("R5 zero", int'(flags[1]), ef[1]);
    chk("R6 sign", int'(flags[2]), ef[2]);
    chk("R7 parity", int'(flags[3]), ef[3]);
    chk(o >= 4 ? "R9 overflow" : "R3 overflow", int'(flags[4]), ef[4]);
    chk(o >= 4 ? "R9 aux" : "R4 aux", int'(flags[5]), ef[5]);
    if (we != 0) exp_q = ef;
    @(posedge clk); #1;
    chk("R11 flags_q", int'(flags_q), int'(exp_q));
  endtask

  initial begin
    #2000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    #1;
    chk("R11 reset flags_q", int'(flags_q), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R11 reset after release", int'(flags_q), 0);
    apply(0, 0, 16'h7FFF, 16'h0001, 0, 1);
    apply(0, 0, 16'hFFFF, 16'h0001, 1, 1);
    apply(1, 0, 16'hFFFF, 16'h0000, 1, 0);
    apply(1, 0, 16'h000F, 16'h0000, 1, 1);
    apply(2, 0, 16'h8000, 16'h0001, 0, 1);
    apply(2, 0, 16'h0000, 16'h0001, 0, 0);
    apply(3, 0, 16'h0010, 16'h0000, 1, 1);
    apply(2, 0, 16'h1234, 16'h1234, 0, 1);
    apply(4, 0, 16'hF0F0, 16'h0FF0, 1, 1);
    apply(5, 0, 16'h8000, 16'h0001, 0, 1);
    apply(6, 0, 16'hAAAA, 16'hAAAA, 0, 0);
    apply(7, 0, 16'hBEEF, 16'h1357, 1, 1);
    apply(0, 1, 16'hAB7F, 16'hCD01, 0, 1);
    apply(0, 1, 16'h12FF, 16'h3401, 0, 1);
    apply(2, 1, 16'hFF80, 16'h0001, 0, 1);
    apply(3, 1, 16'h5500, 16'h6600, 1, 1);
    apply(7, 1, 16'h0000, 16'hA5C3, 0, 1);
    apply(6, 1, 16'h12F0, 16'h340F, 0, 0);
    seed = 32'h1ACE;
    for (int k = 0; k < 150; k++) begin
      seed = seed * 1103515245 + 12345;
      apply((seed >> 8) & 7, (seed >> 12) & 1, (seed >> 3) & 16'hFFFF,
            (seed * 7 >> 13) & 16'hFFFF, (seed >> 20) & 1, (seed >> 22) & 1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule